// File: doc/BRIEF.md
# Packed Float-Integer Lane Converter

This unit converts numbers in each 32-bit lane of a 64-bit operand. The lanes are handled in parallel and neither affects the other. A 2-bit opcode selects the conversion. Two conversions go from single-precision floats to signed integers: one gives a full 32-bit integer, the other gives a 16-bit integer sign-extended to 32 bits. The other two go from signed integers to single-precision floats: one reads the whole 32-bit lane, the other reads only the lower 16 bits of the lane.

Every conversion truncates toward zero. No rounding mode can be chosen. Floats whose exponent field is zero are treated as zero. Float magnitudes below one give integer zero. Results outside the target range clamp to the largest or smallest integer of that width. No flags or exceptions are produced, and infinity or NaN inputs have no defined result. There is one register stage: a valid strobe on the input produces a valid result one clock later. The stage reloads only on cycles where the strobe is high.

Top module: `pkfx_cvt`

## Requirements
- R1: Each 32-bit lane (lane 0 = bits 31:0, lane 1 = bits 63:32) is converted using only its own input bits, so two lanes with different values give independent results in the same cycle.
- R2: Opcode 2'b00 converts a float (sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0 with a hidden leading one) to a 32-bit signed integer, truncating toward zero.
- R3: Opcode 2'b10 converts a float to a 16-bit signed integer, truncating toward zero. Bits 31:16 of the lane result all equal bit 15.
- R4: Opcode 2'b01 converts a 32-bit signed integer to a float, truncating the fraction toward zero. Integer zero gives 32'h0000_0000, and a negative integer sets bit 31 and encodes its magnitude.
- R5: Opcode 2'b11 converts the signed 16-bit value in lane bits 15:0 to a float, truncating toward zero. Lane bits 31:16 are ignored.
- R6: For opcodes 2'b00 and 2'b10, an exponent field below 127 (this includes 0) gives integer 0.
- R7: For a float-to-integer result outside the signed range, the positive limit (32'h7FFF_FFFF, or 16'h7FFF sign-extended) or the negative limit (32'h8000_0000, or 16'h8000 sign-extended) is produced.
- R8: `out_vld` equals `in_vld` delayed by one clock. `out_res` loads the converted value only at a clock where `in_vld` is high and holds otherwise.
- R9: Synchronous active-low reset clears `out_vld` and `out_res` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input operand valid strobe |
| in_op | input | 2 | Conversion select (00 f->i32, 01 i32->f, 10 f->i16, 11 i16->f) |
| in_opnd | input | 64 | Two packed 32-bit lanes |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| out_res | output | 64 | Two packed 32-bit results |

## Verification
The two lanes are converted in the same cycle, and the risk is that a corner case in one lane disturbs the other. The float sweeps therefore put each swept value in lane 0 and a mirrored value in lane 1. In that value the exponent is reflected and the sign flipped, so one lane often saturates while the other flushes to zero. The word sweep fills bits 31:16 with random values. A separate arithmetic model in the bench checks each lane's result against the expected value.

// File: rtl/pkfx_pkg.sv
// Shared constants and opcode type for the packed float-integer converter.
// Assumes single-precision layout: 1 sign, 8 exponent, 23 fraction bits.
package pkfx_pkg;
    localparam int LANE_W = 32;
    localparam int FRAC_W = 23;
    localparam int EXP_W  = 8;
    localparam int BIAS   = 127;

    typedef enum logic [1:0] {
        OP_F2I = 2'b00,
        OP_I2F = 2'b01,
        OP_F2W = 2'b10,
        OP_W2F = 2'b11
    } cvt_op_e;
endpackage

// File: rtl/pkfx_f2i.sv
// Float to signed integer of OUT_W bits, result sign-extended to 32 bits.
// Truncates toward zero; exponent below bias gives 0; out-of-range clamps.
// Assumes OUT_W <= 32 and no infinity/NaN operands.
module pkfx_f2i #(
    parameter int OUT_W = 32
) (
    input  logic [31:0] fp,
    output logic [31:0] res
);
    import pkfx_pkg::*;

    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_SAT = EXP_W'(BIAS + OUT_W - 1);
    localparam logic [31:0]      POS_SAT = 32'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic [31:0]      NEG_SAT = ~POS_SAT;
    localparam int               WIDE_W  = FRAC_W + 1 + 31;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W:0]   man;
    logic [5:0]        sh;
    logic [WIDE_W-1:0] wide;
    logic [31:0]       mag;

    assign sgn = fp[31];
    assign ex  = fp[30:23];
    assign man = {1'b1, fp[FRAC_W-1:0]};

    // Shift the significand to integer position, then apply sign or clamp.
    always_comb begin
        sh   = 6'(ex - EXP_ONE);
        wide = {{(WIDE_W-FRAC_W-1){1'b0}}, man} << sh;
        mag  = 32'(wide >> FRAC_W);
        if (ex < EXP_ONE)
            res = '0;
        else if (ex >= EXP_SAT)
            res = sgn ? NEG_SAT : POS_SAT;
        else
            res = sgn ? (~mag + 32'd1) : mag;
    end
endmodule

// File: rtl/pkfx_i2f.sv
// Signed integer of IN_W bits to single-precision float.
// Truncates dropped fraction bits toward zero; zero gives +0.0.
// Assumes IN_W <= 32.
module pkfx_i2f #(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0] ival,
    output logic [31:0]     fp
);
    import pkfx_pkg::*;

    logic              neg;
    logic [IN_W-1:0]   absv;
    logic [31:0]       ext;
    logic [4:0]        pos;
    logic [FRAC_W-1:0] frac;

    assign neg  = ival[IN_W-1];
    assign absv = neg ? (~ival + {{(IN_W-1){1'b0}}, 1'b1}) : ival;
    assign ext  = 32'(absv);

    // Locate the leading one, normalise it away and pack the fields.
    always_comb begin
        pos = '0;
        for (int i = 0; i < IN_W; i++)
            if (ext[i]) pos = 5'(i);
        frac = FRAC_W'((ext << (5'd31 - pos)) >> 8);
        if (ext == '0)
            fp = '0;
        else
            fp = {neg, EXP_W'(BIAS) + {3'b000, pos}, frac};
    end
endmodule

// File: rtl/pkfx_lane.sv
// One 32-bit lane: runs all four conversions and selects by opcode.
// Assumes op is a valid cvt_op_e; purely combinational.
module pkfx_lane (
    input  pkfx_pkg::cvt_op_e op,
    input  logic [31:0]       din,
    output logic [31:0]       dout
);
    import pkfx_pkg::*;

    logic [31:0] r_f2i, r_f2w, r_i2f, r_w2f;

    pkfx_f2i #(.OUT_W(32)) u_f2i (.fp(din), .res(r_f2i));
    pkfx_f2i #(.OUT_W(16)) u_f2w (.fp(din), .res(r_f2w));
    pkfx_i2f #(.IN_W(32))  u_i2f (.ival(din),       .fp(r_i2f));
    pkfx_i2f #(.IN_W(16))  u_w2f (.ival(din[15:0]), .fp(r_w2f));

    // Select the conversion requested by the opcode.
    always_comb begin
        unique case (op)
            OP_F2I:  dout = r_f2i;
            OP_I2F:  dout = r_i2f;
            OP_F2W:  dout = r_f2w;
            default: dout = r_w2f;
        endcase
    end
endmodule

// File: rtl/pkfx_cvt.sv
// Packed float-integer converter top: LANES parallel lanes plus one
// register stage. out_res loads only when in_vld is high.
// Assumes synchronous active-low reset.
module pkfx_cvt #(
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [1:0]            in_op,
    input  logic [LANES*32-1:0]   in_opnd,
    output logic                  out_vld,
    output logic [LANES*32-1:0]   out_res
);
    import pkfx_pkg::*;

    localparam int TOT_W = LANES * LANE_W;

    logic [TOT_W-1:0] conv;
    cvt_op_e          op_e;

    assign op_e = cvt_op_e'(in_op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pkfx_lane u_lane (
            .op   (op_e),
            .din  (in_opnd[g*LANE_W +: LANE_W]),
            .dout (conv[g*LANE_W +: LANE_W])
        );

        // R3: float-to-word result is sign-extended through the lane.
        assert_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_op == 2'b10) |=>
            (out_res[g*32+31 -: 16] == {16{out_res[g*32+15]}}));

        // R4: sign of an integer-to-float result follows the integer sign.
        assert_i2f_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_op == 2'b01) |=>
            (out_res[g*32+31] == $past(in_opnd[g*32+31])));

        // R6: exponent below bias converts to integer zero.
        assert_tiny_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && !in_op[0] && in_opnd[g*32+30 -: 8] < 8'd127) |=>
            (out_res[g*32 +: 32] == 32'd0));

        // R7: large positive float clamps to the 32-bit positive limit.
        assert_sat_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_op == 2'b00 && !in_opnd[g*32+31] &&
             in_opnd[g*32+30 -: 8] >= 8'd158) |=>
            (out_res[g*32 +: 32] == 32'h7FFF_FFFF));
    end

    // Output stage: valid follows strobe, data loads only on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_res <= conv;
        end
    end

    // R8: valid is the strobe delayed by one clock.
    assert_vld_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_vld_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R8: data holds while no strobe arrives.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_res));
endmodule

// File: tb/sim_pkfx_cvt.sv
// Self-checking bench: float sweeps over every exponent, integer corners and
// random values, an exhaustive 16-bit word sweep, hold and reset checks.
module sim_pkfx_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_opnd = '0;
    logic        out_vld;
    logic [63:0] out_res;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_exp = '0;

    always #4 clk = ~clk;

    pkfx_cvt #(.LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_opnd(in_opnd), .out_vld(out_vld), .out_res(out_res)
    );

    function automatic real pow2(input int n);
        real r = 1.0;
        if (n >= 0) repeat (n) r = r * 2.0;
        else repeat (-n) r = r / 2.0;
        return r;
    endfunction

    function automatic logic [31:0] f2i_ref(input logic [31:0] f, input int w);
        int  ei = int'(f[30:23]);
        real v, lim;
        if (ei == 0) return 32'd0;
        v = (1.0 + real'(f[22:0]) / 8388608.0) * pow2(ei - 127);
        if (f[31]) v = -v;
        lim = pow2(w - 1);
        if (v >= lim) return 32'((64'd1 << (w - 1)) - 64'd1);
        if (v <= -lim) return ~32'((64'd1 << (w - 1)) - 64'd1);
        return 32'($rtoi(v));
    endfunction

    function automatic logic [31:0] i2f_ref(input longint x);
        longint m;
        longint fr;
        int e = 0;
        logic s;
        if (x == 0) return 32'd0;
        s = (x < 0);
        m = s ? -x : x;
        while ((m >> e) > 1) e++;
        fr = ((m << 23) >> e) & 64'h7F_FFFF;
        return {s, 8'(127 + e), fr[22:0]};
    endfunction

    function automatic logic [31:0] exp_lane(input logic [1:0] op, input logic [31:0] x);
        case (op)
            2'b00:   return f2i_ref(x, 32);
            2'b10:   return f2i_ref(x, 16);
            2'b01:   return i2f_ref(longint'($signed(x)));
            default: return i2f_ref(longint'($signed(x[15:0])));
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] op, input logic [31:0] x);
        if (op == 2'b01) return "R4";
        if (op == 2'b11) return "R5";
        if (x[30:23] < 8'd127) return "R6";
        if ((op == 2'b00 && x[30:23] >= 8'd158) || (op == 2'b10 && x[30:23] >= 8'd142))
            return "R7";
        return (op == 2'b00) ? "R2" : "R3";
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] got,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, expv);
        end
    endtask

    // Apply one valid operand, sample after the capturing edge, check both lanes.
    task automatic step(input logic [1:0] op, input logic [63:0] d);
        logic [31:0] e0, e1;
        in_op = op; in_opnd = d; in_vld = 1'b1;
        e0 = exp_lane(op, d[31:0]);
        e1 = exp_lane(op, d[63:32]);
        @(posedge clk); #2;
        check(out_vld == 1'b1, "R8 valid", {63'd0, out_vld}, 64'd1);
        check(out_res[31:0] == e0, {tag_for(op, d[31:0]), " lane0"},
              {32'd0, out_res[31:0]}, {32'd0, e0});
        check(out_res[63:32] == e1, {tag_for(op, d[63:32]), " lane1 R1"},
              {32'd0, out_res[63:32]}, {32'd0, e1});
        last_exp = {e1, e0};
    endtask

    // Drop the strobe with a new operand: result must hold and valid fall.
    task automatic idle_check(input logic [63:0] d);
        in_vld = 1'b0; in_op = 2'b01; in_opnd = d;
        @(posedge clk); #2;
        check(out_vld == 1'b0, "R8 valid low", {63'd0, out_vld}, 64'd0);
        check(out_res == last_exp, "R8 hold", out_res, last_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset dominates a strobe held high.
        in_vld = 1'b1; in_op = 2'b01; in_opnd = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(posedge clk);
        #2;
        check(out_vld == 1'b0, "R9 valid", {63'd0, out_vld}, 64'd0);
        check(out_res == 64'd0, "R9 data", out_res, 64'd0);
        rst_n = 1'b1;

        // R2/R3/R6/R7 with R1: every exponent, mirrored partner in lane 1.
        for (int op = 0; op < 4; op += 2) begin
            for (int e = 0; e < 256; e++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [22:0] fr;
                        logic [31:0] a, b;
                        fr = (k == 0) ? 23'd0 : (k == 1) ? 23'd1 :
                             (k == 2) ? 23'h40_0000 : 23'h7F_FFFF;
                        a = {s[0], e[7:0], fr};
                        b = {~s[0], 8'(255 - e), ~fr};
                        step(op[1:0], {b, a});
                    end
                end
            end
        end

        // R4: integer corners and truncation cases.
        step(2'b01, {32'hFFFF_FFFF, 32'h0000_0000});
        step(2'b01, {32'h8000_0000, 32'h7FFF_FFFF});
        step(2'b01, {32'h0100_0001, 32'h00FF_FFFF});
        step(2'b01, {32'hFEFF_FFFF, 32'h0000_0001});
        for (int i = 0; i < 32; i++)
            step(2'b01, {~(32'd1 << i), 32'd1 << i});
        for (int i = 0; i < 3000; i++)
            step(2'b01, {$urandom, $urandom});

        // R5: exhaustive 16-bit words, random upper halves ignored.
        for (int w = 0; w < 32768; w++) begin
            logic [15:0] lo0, lo1;
            lo0 = w[15:0];
            lo1 = 16'(w + 32768);
            step(2'b11, {16'($urandom), lo1, 16'($urandom), lo0});
        end

        // R8: strobe drops hold the last result.
        step(2'b00, {32'h4120_0000, 32'hC2F6_E979});
        idle_check(64'hDEAD_BEEF_0BAD_F00D);
        idle_check(64'h0000_0001_FFFF_FFFF);
        step(2'b10, {32'h4780_0000, 32'hC700_0000});
        idle_check(64'h3F80_0000_BF80_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule